// File: doc/BRIEF.md
# Core Wake-Up Handshake Sequencer

This block follows the wake-up handshake of a single processor core. The core starts parked, waiting for an INIT message. INIT arms it, and a following start-up message carrying an 8-bit vector releases it. On release the block raises a run-enable and presents the start location the core must begin fetching from. That location is an instruction pointer of zero and a code segment whose selector and base are both derived from the vector. One instance sits beside each core. The message router upstream hands it already-decoded per-core delivery strobes.

Messages that arrive out of order or more than once are absorbed by the current state. An INIT after the core is armed or running does nothing. This makes the common INIT, INIT, start-up pattern work. A start-up message that arrives while the core is not armed also does nothing. Every absorbed message raises a one-cycle flag that neighbouring checking logic can observe. The start state, once set, holds until a synchronous reset.

Top module: `core_wake_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are: `seq_state` = 0, `run_en` = 0, `msg_ignored` = 0, and `cs_sel`, `cs_base`, `cs_limit` and `ip` all zero.
- R2: `seq_state` codes are 0 = waiting for INIT, 1 = waiting for start-up, 2 = started. A strobe (`evt_valid` = 1) with `evt_kind` = 0 (INIT) in state 0 moves to state 1 at that edge.
- R3: An INIT strobe in state 1 or 2 leaves the state and all start outputs unchanged, and `msg_ignored` is 1 for the following cycle.
- R4: A start-up strobe (`evt_kind` = 1) in state 0 or 2 leaves the state, `run_en` and all start outputs unchanged, and `msg_ignored` is 1 for the following cycle.
- R5: A start-up strobe in state 1 sets `cs_sel` to the vector shifted left by 8 bits and `ip` to 0.
- R6: A start-up strobe in state 1 sets `cs_base` to the vector shifted left by 12 bits and `cs_limit` to 0xFFFF.
- R7: A start-up strobe in state 1 sets `run_en` to 1 and `seq_state` to 2.
- R8: Once set, `run_en` and the start outputs hold until reset; a reset returns the block to state 0 with `run_en` low.
- R9: `msg_ignored` is 0 in any cycle that follows an edge with no strobe or with an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Delivery strobe for this core, one cycle per message |
| evt_kind | input | 1 | Message kind: 0 = INIT, 1 = start-up |
| evt_vector | input | VEC_W (8) | Start-up vector |
| seq_state | output | 2 | Handshake state: 0 wait INIT, 1 wait start-up, 2 started |
| run_en | output | 1 | Core released to run |
| cs_sel | output | SEL_W (16) | Code segment selector at start |
| cs_base | output | BASE_W (32) | Code segment base at start |
| cs_limit | output | LIM_W (32) | Code segment limit at start |
| ip | output | IP_W (32) | Instruction pointer at start |
| msg_ignored | output | 1 | One-cycle pulse after an absorbed message |

## Verification
The hardest situation to reach from the ports is a second start-up message once the core is already running, carrying a different vector. Only then can the bench show that the held start address is not overwritten. Random streams rarely produce that order after a fresh reset. The bench therefore forces it directly. It sends INIT, INIT, start-up with vector 0x9A, then a start-up with 0x33 and another INIT, and checks that the address still reflects 0x9A. Random streams with occasional resets then mix every message kind into every state, including the extreme vectors 0x00 and 0xFF.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  typedef enum logic [1:0] {
    WK_WAIT_INIT  = 2'd0,
    WK_WAIT_START = 2'd1,
    WK_STARTED    = 2'd2
  } wake_state_t;

  typedef enum logic {
    MSG_INIT  = 1'b0,
    MSG_START = 1'b1
  } wake_msg_t;

  localparam int unsigned SEL_SHIFT  = 8;
  localparam int unsigned BASE_SHIFT = 12;
  localparam logic [15:0] START_LIMIT = 16'hFFFF;

endpackage

// File: rtl/core_wake_fsm.sv
module core_wake_fsm
  import core_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        evt_valid,
  input  logic        evt_kind,
  output logic        take_start,
  output logic [1:0]  state_q,
  output logic        run_q,
  output logic        ignored_q
);

  wake_state_t cur_st, nxt_st;
  logic take_init;
  logic drop_msg;

  always_comb begin
    take_init  = evt_valid && (evt_kind == MSG_INIT)  && (cur_st == WK_WAIT_INIT);
    take_start = evt_valid && (evt_kind == MSG_START) && (cur_st == WK_WAIT_START);
    drop_msg   = evt_valid && !take_init && !take_start;
    nxt_st     = cur_st;
    if (take_init)  nxt_st = WK_WAIT_START;
    if (take_start) nxt_st = WK_STARTED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_st    <= WK_WAIT_INIT;
      run_q     <= 1'b0;
      ignored_q <= 1'b0;
    end else begin
      cur_st    <= nxt_st;
      ignored_q <= drop_msg;
      if (take_start) run_q <= 1'b1;
    end
  end

  assign state_q = cur_st;

endmodule

// File: rtl/core_wake_addr.sv
module core_wake_addr
  import core_wake_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 32,
  parameter int unsigned IP_W   = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [VEC_W-1:0]  vector,
  output logic [SEL_W-1:0]  sel_q,
  output logic [BASE_W-1:0] base_q,
  output logic [LIM_W-1:0]  lim_q,
  output logic [IP_W-1:0]   ip_q
);

  localparam int unsigned SEL_RAW_W  = VEC_W + SEL_SHIFT;
  localparam int unsigned BASE_RAW_W = VEC_W + BASE_SHIFT;

  logic [SEL_RAW_W-1:0]  sel_raw;
  logic [BASE_RAW_W-1:0] base_raw;

  always_comb begin
    sel_raw  = {vector, {SEL_SHIFT{1'b0}}};
    base_raw = {vector, {BASE_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
      ip_q   <= '0;
    end else if (load) begin
      sel_q  <= SEL_W'(sel_raw);
      base_q <= BASE_W'(base_raw);
      lim_q  <= LIM_W'(START_LIMIT);
      ip_q   <= '0;
    end
  end

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 32,
  parameter int unsigned IP_W   = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic              evt_kind,
  input  logic [VEC_W-1:0]  evt_vector,
  output logic [1:0]        seq_state,
  output logic              run_en,
  output logic [SEL_W-1:0]  cs_sel,
  output logic [BASE_W-1:0] cs_base,
  output logic [LIM_W-1:0]  cs_limit,
  output logic [IP_W-1:0]   ip,
  output logic              msg_ignored
);

  logic start_ok;

  core_wake_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .take_start (start_ok),
    .state_q    (seq_state),
    .run_q      (run_en),
    .ignored_q  (msg_ignored)
  );

  core_wake_addr #(
    .VEC_W  (VEC_W),
    .SEL_W  (SEL_W),
    .BASE_W (BASE_W),
    .LIM_W  (LIM_W),
    .IP_W   (IP_W)
  ) u_addr (
    .clk    (clk),
    .rst    (rst),
    .load   (start_ok),
    .vector (evt_vector),
    .sel_q  (cs_sel),
    .base_q (cs_base),
    .lim_q  (cs_limit),
    .ip_q   (ip)
  );

endmodule

// File: rtl/core_wake_seq_chk.sv
module core_wake_seq_chk #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned BASE_W = 32,
  parameter int unsigned LIM_W  = 32,
  parameter int unsigned IP_W   = 32
)(
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              evt_kind,
  input logic [VEC_W-1:0]  evt_vector,
  input logic [1:0]        seq_state,
  input logic              run_en,
  input logic [SEL_W-1:0]  cs_sel,
  input logic [BASE_W-1:0] cs_base,
  input logic [LIM_W-1:0]  cs_limit,
  input logic [IP_W-1:0]   ip,
  input logic              msg_ignored
);

  // R2
  init_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_kind && seq_state == 2'd0) |=> (seq_state == 2'd1));

  // R3
  late_init_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_kind && seq_state != 2'd0)
      |=> ($stable(seq_state) && $stable(cs_sel) && msg_ignored));

  // R4
  stray_start_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind && seq_state != 2'd1)
      |=> ($stable(seq_state) && $stable(run_en) && $stable(cs_base) && msg_ignored));

  // R5
  start_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind && seq_state == 2'd1)
      |=> (cs_sel == SEL_W'({$past(evt_vector), 8'h00}) && ip == '0));

  // R6
  start_base_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind && seq_state == 2'd1)
      |=> (cs_base == BASE_W'({$past(evt_vector), 12'h000}) && cs_limit == LIM_W'(16'hFFFF)));

  // R7
  start_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind && seq_state == 2'd1) |=> (run_en && seq_state == 2'd2));

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    run_en |=> (run_en && $stable(cs_sel) && $stable(cs_base)));

  // R9
  quiet_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid) |=> !msg_ignored);

endmodule

bind core_wake_seq core_wake_seq_chk #(
  .VEC_W(VEC_W), .SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .IP_W(IP_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
  .evt_vector(evt_vector), .seq_state(seq_state), .run_en(run_en),
  .cs_sel(cs_sel), .cs_base(cs_base), .cs_limit(cs_limit), .ip(ip),
  .msg_ignored(msg_ignored)
);

// File: tb/tb_core_wake_seq.sv
module tb_core_wake_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic        evt_kind = 1'b0;
  logic [7:0]  evt_vector = 8'h00;
  logic [1:0]  seq_state;
  logic        run_en;
  logic [15:0] cs_sel;
  logic [31:0] cs_base;
  logic [31:0] cs_limit;
  logic [31:0] ip;
  logic        msg_ignored;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int          m_state;
  bit          m_run;
  logic [31:0] m_sel, m_base, m_lim, m_ip;
  bit          m_ign;

  always #4 clk = ~clk;

  core_wake_seq dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_vector(evt_vector), .seq_state(seq_state), .run_en(run_en),
    .cs_sel(cs_sel), .cs_base(cs_base), .cs_limit(cs_limit), .ip(ip),
    .msg_ignored(msg_ignored)
  );

  function automatic logic [31:0] sel_of(input logic [7:0] v);
    return {16'h0, v, 8'h00};
  endfunction

  function automatic logic [31:0] base_of(input logic [7:0] v);
    return {12'h0, v, 12'h000};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_run = 0; m_ign = 0;
    m_sel = '0; m_base = '0; m_lim = '0; m_ip = '0;
  endtask

  // one clock: drive at negedge, sample at following negedge
  task automatic step(input bit do_rst, input bit v, input bit k, input logic [7:0] vec);
    string tag;
    rst = do_rst; evt_valid = v; evt_kind = k; evt_vector = vec;
    @(negedge clk);
    rst = 1'b0; evt_valid = 1'b0;
    if (do_rst) begin
      model_reset(); tag = "R1";
    end else if (!v) begin
      m_ign = 0; tag = "R9";
    end else if (!k) begin
      if (m_state == 0) begin m_state = 1; m_ign = 0; tag = "R2"; end
      else begin m_ign = 1; tag = "R3"; end
    end else begin
      if (m_state == 1) begin
        m_state = 2; m_run = 1; m_ign = 0; tag = "R7";
        m_sel = sel_of(vec); m_base = base_of(vec); m_lim = 32'hFFFF; m_ip = 0;
      end else begin m_ign = 1; tag = "R4"; end
    end
    check(tag, "state",   32'(seq_state),   32'(m_state));
    check(tag, "run_en",  32'(run_en),      32'(m_run));
    check(tag, "ignored", 32'(msg_ignored), 32'(m_ign));
    check("R5", "cs_sel", 32'(cs_sel),      m_sel);
    check("R5", "ip",     ip,               m_ip);
    check("R6", "cs_base", cs_base,         m_base);
    check("R6", "cs_limit", cs_limit,       m_lim);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    // R1 reset state
    step(1, 0, 0, 8'h00);
    // R4 start-up before INIT is dropped
    step(0, 1, 1, 8'h55);
    step(0, 0, 0, 8'h00);
    // R2 then R3: INIT, INIT, start-up
    step(0, 1, 0, 8'h00);
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'h9A);
    // R8 held start state; R4 second start-up and R3 INIT after start
    step(0, 1, 1, 8'h33);
    step(0, 1, 0, 8'h00);
    step(0, 0, 0, 8'h00);
    // R8 reset clears; extreme vectors for R5 and R6
    step(1, 0, 0, 8'h00);
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'hFF);
    step(1, 0, 0, 8'h00);
    step(0, 1, 0, 8'h00);
    step(0, 1, 1, 8'h00);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4)       step(1, 0, 0, 8'h00);
      else if (r < 30) step(0, 0, 0, 8'($urandom));
      else if (r < 65) step(0, 1, 0, 8'($urandom));
      else             step(0, 1, 1, 8'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule